// File: doc/BRIEF.md
# Beam-Break Batch Counter

This block counts objects travelling past an optical beam and groups them into batches of five. It receives the raw sensor level, which is high while the beam is lit and drops low while an object blocks it. The level is synchronized and then filtered: a change is accepted only after it has been stable for a programmable number of clock cycles. Each accepted lit-to-blocked change is one count event. This gives one count per object, even when a slow edge bounces, and it enforces a minimum spacing between events.

Count events step a five-stage twisted-ring (Johnson) state. The state is decoded into five one-hot position outputs. An event at position 4 returns the ring to position 0 on the same clock edge, so the terminal position never appears on the outputs. That edge also raises a one-cycle batch-complete strobe.

An active-low count-enable input drops events while it is high. A synchronous reset takes priority over everything else. A ring pattern outside the five legal ones is forced back to position 0 on the next clock.

Top module: `beam_batch_counter`

## Requirements
- R1: While rst_n is low at a clock edge, the block goes to position 0 after that edge (pos_q = 5'b00001) and batch_done is low.
- R2: Outside reset, exactly one bit of pos_q is high. Bit i means position i.
- R3: The block counts one event when sensor_lit falls and stays low for at least STABLE_CYCLES synchronized cycles. Each event moves pos_q one position in the order 0, 1, 2, 3, 4.
- R4: An event taken at position 4 sets pos_q to position 0 on the same edge that raises batch_done. batch_done stays high for exactly one cycle, and it never rises at any other time.
- R5: A low pulse on sensor_lit that is shorter than STABLE_CYCLES cycles is ignored. A blockage whose edges bounce in single-cycle pulses gives exactly one event.
- R6: While count_en_n is high, events are dropped, and neither pos_q nor batch_done changes.
- R7: Reset takes priority over a count event, even one that would complete a batch. No batch_done is produced in that case, and counting starts again from position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sensor_lit | input | 1 | Raw beam level: high when lit, low when blocked (asynchronous) |
| count_en_n | input | 1 | Count enable, active low; high drops count events |
| pos_q | output | 5 | One-hot position 0..4, registered |
| batch_done | output | 1 | One-cycle strobe when position 4 wraps to 0 |

## Verification
Two pairs of functions can fall on the same edge, and each pair is provoked on purpose.

The first pair is the batch wrap and reset. The counter is brought to position 4, and reset is asserted while a fifth blockage is being accepted. The outcome is judged by pos_q returning to position 0 with no batch_done pulse recorded.

The second pair is the batch wrap and the inhibit. A fifth blockage is presented at position 4 with count_en_n high. The result must be that position 4 holds and no strobe appears.

Randomly mixed objects, glitches, bounced edges and inhibited objects are then compared against a position model held in the bench.

// File: rtl/beam_batch_pkg.sv
// Shared constants and helpers for the beam-break batch counter.
// Assumes a five-stage ring whose bit 0 is the first stage.
package beam_batch_pkg;

    localparam int RING_W = 5;
    localparam int NPOS   = 5;

    typedef logic [RING_W-1:0] ring_t;
    typedef logic [NPOS-1:0]   pos_t;

    // A legal pattern is a run of ones starting at bit 0, with the last stage clear.
    function automatic logic ring_legal(ring_t r);
        logic ok;
        ok = ~r[RING_W-1];
        for (int i = 1; i < RING_W; i++) begin
            if (r[i] && !r[i-1]) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/beam_sync_filter.sv
// Synchronizes the raw beam level and accepts a level change only after
// it has held for STABLE_CYCLES cycles. It emits a one-cycle pulse on each
// accepted lit-to-blocked change.
// Assumes sensor_lit is asynchronous and that the beam is lit at reset.
module beam_sync_filter #(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sensor_lit,
    output logic block_evt
);
    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level_q;
    logic [CNT_W-1:0]       hold_cnt;
    logic                   synced;

    // Synchronizer chain, one flop per stage.
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // Purpose: first capture of the asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b1;
                    else        sync_q[0] <= sensor_lit;
                end
            end else begin : g_next
                // Purpose: further metastability settling stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign synced = sync_q[SYNC_STAGES-1];

    // Purpose: stability filter and edge pulse for a newly accepted blockage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q   <= 1'b1;
            hold_cnt  <= '0;
            block_evt <= 1'b0;
        end else begin
            block_evt <= 1'b0;
            if (synced != level_q) begin
                if (hold_cnt == CNT_LAST) begin
                    level_q   <= synced;
                    hold_cnt  <= '0;
                    block_evt <= ~synced;
                end else begin
                    hold_cnt <= hold_cnt + 1'b1;
                end
            end else begin
                hold_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/johnson_ring.sv
// Five-stage twisted-ring state with a synchronous wrap at position 4.
// It computes the next state for the output decoder and a wrap strobe.
// Assumes advance is a single-cycle, already qualified event.
module johnson_ring
    import beam_batch_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  advance,
    output ring_t ring_q,
    output ring_t ring_d,
    output logic  wrap_q
);
    logic at_last;
    logic wrap_d;
    logic bad;

    // Position 4 has stage 4 set and stage 5 clear.
    assign at_last = ring_q[RING_W-2] & ~ring_q[RING_W-1];
    // An illegal pattern or the terminal pattern is an error.
    assign bad     = ~ring_legal(ring_q) | (ring_q[0] & ring_q[RING_W-1]);

    // Purpose: next-state selection among recover, wrap, shift and hold.
    always_comb begin
        ring_d = ring_q;
        wrap_d = 1'b0;
        if (bad) begin
            ring_d = '0;
        end else if (advance) begin
            if (at_last) begin
                ring_d = '0;
                wrap_d = 1'b1;
            end else begin
                ring_d = {ring_q[RING_W-2:0], ~ring_q[RING_W-1]};
            end
        end
    end

    // Purpose: ring state and wrap strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q <= '0;
            wrap_q <= 1'b0;
        end else begin
            ring_q <= ring_d;
            wrap_q <= wrap_d;
        end
    end

endmodule

// File: rtl/johnson_decode.sv
// Two-input decode of a twisted-ring pattern into one-hot positions.
// Assumes the input is one of the five legal patterns.
module johnson_decode
    import beam_batch_pkg::*;
(
    input  ring_t ring,
    output pos_t  pos
);
    genvar i;
    generate
        for (i = 0; i < NPOS; i++) begin : g_pos
            if (i == 0) begin : g_zero
                assign pos[0] = ~ring[0] & ~ring[RING_W-1];
            end else begin : g_mid
                assign pos[i] = ring[i-1] & ~ring[i];
            end
        end
    endgenerate

endmodule

// File: rtl/beam_batch_counter.sv
// Top level: conditioned beam events step the twisted-ring state. The
// decoded positions are registered so that each output leaves one flop.
// Assumes a single clock and a synchronous active-low reset.
module beam_batch_counter
    import beam_batch_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sensor_lit,
    input  logic             count_en_n,
    output logic [NPOS-1:0]  pos_q,
    output logic             batch_done
);
    logic  block_evt;
    logic  advance;
    ring_t ring_q;
    ring_t ring_d;
    pos_t  pos_next;

    beam_sync_filter #(
        .SYNC_STAGES   (SYNC_STAGES),
        .STABLE_CYCLES (STABLE_CYCLES)
    ) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sensor_lit (sensor_lit),
        .block_evt  (block_evt)
    );

    assign advance = block_evt & ~count_en_n;

    johnson_ring u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .ring_q  (ring_q),
        .ring_d  (ring_d),
        .wrap_q  (batch_done)
    );

    johnson_decode u_dec (
        .ring (ring_d),
        .pos  (pos_next)
    );

    // Purpose: register the decoded positions in step with the ring state.
    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= NPOS'(1);
        else        pos_q <= pos_next;
    end

endmodule

// File: rtl/beam_batch_chk.sv
// Property checker for beam_batch_counter, attached by bind.
module beam_batch_chk
    import beam_batch_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            count_en_n,
    input logic [NPOS-1:0] pos_q,
    input logic            batch_done,
    input ring_t           ring_q
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pos_q == NPOS'(1) && !batch_done));

    assert_one_hot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pos_q) == 1);

    assert_ring_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ring_legal(ring_q));

    assert_step_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(pos_q)) |->
            (pos_q == {$past(pos_q[NPOS-2:0]), $past(pos_q[NPOS-1])}));

    assert_wrap_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        batch_done |-> (pos_q[0] && $past(pos_q[NPOS-1]) && $past(rst_n)));

    assert_wrap_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pos_q[NPOS-1]) && pos_q[0]) |-> batch_done);

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        batch_done |=> !batch_done);

    assert_inhibit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count_en_n |=> ($stable(pos_q) && !batch_done));

endmodule

bind beam_batch_counter beam_batch_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_en_n (count_en_n),
    .pos_q      (pos_q),
    .batch_done (batch_done),
    .ring_q     (ring_q)
);

// File: tb/beam_batch_counter_bench.sv
`timescale 1ns/1ps
module beam_batch_counter_bench;
    localparam int STABLE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sensor_lit = 1'b1;
    logic       count_en_n = 1'b0;
    logic [4:0] pos_q;
    logic       batch_done;

    int checks = 0;
    int errors = 0;
    int exp_pos = 0;
    int exp_wraps = 0;
    int seen_wraps = 0;
    int wide_strobes = 0;
    logic bd_prev = 1'b0;
    bit finished = 0;

    always #2 clk = ~clk;

    beam_batch_counter #(.SYNC_STAGES(2), .STABLE_CYCLES(STABLE)) u_beam_batch_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sensor_lit (sensor_lit),
        .count_en_n (count_en_n),
        .pos_q      (pos_q),
        .batch_done (batch_done)
    );

    function automatic logic [4:0] pos_vec(int p);
        return 5'(1 << p);
    endfunction

    function automatic int next_pos(int p);
        return (p == 4) ? 0 : p + 1;
    endfunction

    // Strobe monitor, sampled shortly after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && batch_done) begin
            seen_wraps++;
            if (bd_prev) wide_strobes++;
        end
        bd_prev = rst_n && batch_done;
    end

    task automatic check_pos(string tag);
        checks++;
        if (pos_q !== pos_vec(exp_pos)) begin
            errors++;
            $display("FAIL %s: pos_q=%b expected %b", tag, pos_q, pos_vec(exp_pos));
        end
    endtask

    task automatic check_wraps(string tag);
        checks++;
        if (seen_wraps != exp_wraps) begin
            errors++;
            $display("FAIL %s: batch strobes=%0d expected %0d", tag, seen_wraps, exp_wraps);
        end
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // One object: optional bounce at each edge, a blockage, then a lit gap.
    task automatic pass_object(int lo, int bounce, bit counted);
        for (int b = 0; b < bounce; b++) begin
            sensor_lit = 1'b0; wait_cycles(1);
            sensor_lit = 1'b1; wait_cycles(1);
        end
        sensor_lit = 1'b0;
        wait_cycles(lo);
        for (int b = 0; b < bounce; b++) begin
            sensor_lit = 1'b1; wait_cycles(1);
            sensor_lit = 1'b0; wait_cycles(1);
        end
        sensor_lit = 1'b1;
        wait_cycles(14);
        if (counted) begin
            if (exp_pos == 4) exp_wraps++;
            exp_pos = next_pos(exp_pos);
        end
    endtask

    task automatic glitch(int len);
        sensor_lit = 1'b0;
        wait_cycles(len);
        sensor_lit = 1'b1;
        wait_cycles(14);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7411));
        // R1: reset state
        wait_cycles(5);
        check_pos("R1 during reset");
        checks++;
        if (batch_done !== 1'b0) begin
            errors++;
            $display("FAIL R1: batch_done=%b expected 0", batch_done);
        end
        rst_n = 1'b1;
        wait_cycles(5);
        check_pos("R1 after release");

        // R3: step through positions 1..4
        for (int k = 0; k < 4; k++) begin
            pass_object(10, 0, 1'b1);
            check_pos("R3 advance");
        end
        // R4: wrap from position 4
        pass_object(12, 0, 1'b1);
        check_pos("R4 wrap to zero");
        check_wraps("R4 one strobe");

        // R5: short glitches and bounced edges
        glitch(1);
        glitch(STABLE - 1);
        check_pos("R5 glitch ignored");
        pass_object(10, 3, 1'b1);
        check_pos("R5 bounced blockage counts once");

        // R6: inhibit drops an event
        count_en_n = 1'b1;
        pass_object(12, 0, 1'b0);
        count_en_n = 1'b0;
        check_pos("R6 inhibited hold");
        while (exp_pos != 4) pass_object(9, 0, 1'b1);
        check_pos("R3 reach position 4");
        // R6: inhibit at position 4, where a wrap would otherwise occur
        count_en_n = 1'b1;
        pass_object(12, 1, 1'b0);
        count_en_n = 1'b0;
        check_pos("R6 inhibited at position 4");
        check_wraps("R6 no strobe when inhibited");

        // R7: reset arrives while a wrap event is being accepted
        sensor_lit = 1'b0;
        wait_cycles(3);
        rst_n = 1'b0;
        wait_cycles(4);
        sensor_lit = 1'b1;
        wait_cycles(4);
        rst_n = 1'b1;
        wait_cycles(14);
        exp_pos = 0;
        check_pos("R7 reset wins over wrap");
        check_wraps("R7 no strobe");
        pass_object(10, 0, 1'b1);
        check_pos("R7 counting resumes from zero");

        // Random mix of objects, glitches, bounces and inhibited objects
        for (int it = 0; it < 80; it++) begin
            int kind;
            kind = int'($urandom_range(0, 3));
            case (kind)
                0: pass_object(int'($urandom_range(STABLE + 4, 16)), 0, 1'b1);
                1: pass_object(int'($urandom_range(STABLE + 4, 16)), int'($urandom_range(1, 3)), 1'b1);
                2: glitch(int'($urandom_range(1, STABLE - 1)));
                default: begin
                    count_en_n = 1'b1;
                    pass_object(int'($urandom_range(STABLE + 4, 16)), 0, 1'b0);
                    count_en_n = 1'b0;
                end
            endcase
            check_pos("R3 random sequence");
        end
        check_wraps("R4 random strobes");
        checks++;
        if (wide_strobes != 0) begin
            errors++;
            $display("FAIL R4: wide strobes=%0d expected 0", wide_strobes);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule